// File: doc/BRIEF.md
# Normalized Sequential Restoring Divider

This block divides a 16-bit unsigned dividend by a 4-bit unsigned divisor. It returns the integer quotient and the remainder. It uses restoring division and produces one quotient bit per clock. When an operation is accepted, the divisor is shifted left until its most significant bit is set, which puts it in the range 8 to 15. The number of places shifted, s (0 to 3), is stored. Because the normalized divisor is at least 8, the quotient against it fits in 13 bits, so 13 restoring steps are enough to cover the whole dividend.

A correction phase follows the 13 steps and recovers the true quotient. It runs s more steps, one per clock. Each step compares the current remainder against the normalized divisor shifted right by one more place than the last, so the final step compares against the original divisor. Each step shifts the quotient left by one and appends the result of the comparison. When the phase ends, the quotient is exact and the remainder is smaller than the original divisor.

The interface is a one-cycle start pulse, a busy level and a one-cycle done pulse. Operands are captured on the accepting clock edge. A zero divisor needs no iteration: it completes at once with an error flag raised.

Top module: `ndiv_core`

## Requirements
- R1: After reset, busy, done, div_by_zero, quotient and remainder are all 0.
- R2: When start is high and busy is low at a rising edge, dividend and divisor are captured. For a non-zero divisor, busy is high in the cycle after that edge.
- R3: For a non-zero divisor, done is high in the cycle after the (13+s)-th rising edge following the accepting edge. s is the number of leading zero bits of the 4-bit divisor: 8..15 gives 0, 4..7 gives 1, 2..3 gives 2, and 1 gives 3.
- R4: When done is high for a non-zero divisor, quotient equals floor(dividend / divisor).
- R5: When done is high for a non-zero divisor, remainder equals dividend mod divisor, which is always less than the divisor.
- R6: done is high for exactly one cycle per operation and is never high at the same time as busy. busy stays high from the cycle after acceptance until done rises.
- R7: For a zero divisor, done is high in the cycle right after the accepting edge, busy stays low, div_by_zero is 1, quotient is 16'hFFFF and remainder is 0.
- R8: A start pulse while busy is high is ignored. The running operation finishes with its original operands and its original latency.
- R9: quotient, remainder and div_by_zero keep their values from done until the next accepted start.
- R10: An accepted operation with a non-zero divisor clears div_by_zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | 16 | Unsigned dividend, sampled on acceptance |
| divisor | input | 4 | Unsigned divisor, sampled on acceptance |
| busy | output | 1 | High while the division is in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| quotient | output | 16 | Integer quotient |
| remainder | output | 4 | Integer remainder |
| div_by_zero | output | 1 | Set when the last accepted divisor was zero |

## Verification
The bound checker captures the operands itself. On every done it checks that quotient times divisor plus remainder rebuilds the dividend and that the remainder is below the divisor. It also checks the zero-divisor response, that the latency falls inside the allowed window, that the done pulse is one cycle and never overlaps busy, and that the results hold while idle. Only the bench's scenarios show the exact cycle count for each shift amount, the rejection of a start that arrives mid-operation, and the clearing of the error flag after a zero divisor.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
   // Phase of an operation in flight: main restoring steps, then correction steps
   typedef enum logic {
      PH_MAIN = 1'b0,
      PH_FIX  = 1'b1
   } ndiv_phase_e;
endpackage

// File: rtl/ndiv_norm.sv
// Shifts a divisor left until its top bit is set and reports the shift amount.
module ndiv_norm #(
   parameter int VW = 4,
   parameter int SW = 2
) (
   input  logic [VW-1:0] dvs_in,
   output logic [VW-1:0] dvs_norm,
   output logic [SW-1:0] shamt
);
   always_comb begin
      shamt = '0;
      for (int i = 0; i < VW; i++) begin
         if (dvs_in[i]) shamt = SW'(VW - 1 - i);
      end
      dvs_norm = dvs_in << shamt;
   end
endmodule

// File: rtl/ndiv_step.sv
// One trial subtraction: keep the difference only when it is not negative.
module ndiv_step #(
   parameter int VW = 4
) (
   input  logic [VW:0]   part,
   input  logic [VW-1:0] dsub,
   output logic [VW-1:0] rem_out,
   output logic          qbit
);
   logic [VW:0] diff;

   always_comb begin
      diff    = part - {1'b0, dsub};
      qbit    = (part >= {1'b0, dsub});
      rem_out = qbit ? VW'(diff) : VW'(part);
   end
endmodule

// File: rtl/ndiv_core.sv
module ndiv_core #(
   parameter int DW = 16,
   parameter int VW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [VW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quotient,
   output logic [VW-1:0] remainder,
   output logic          div_by_zero
);
   import ndiv_pkg::*;

   localparam int ITERS = DW - VW + 1;
   localparam int SW    = (VW > 2) ? $clog2(VW) : 1;
   localparam int CW    = $clog2(ITERS + VW);

   generate
      if (VW < 2) begin : g_bad_vw
         $error("ndiv_core: VW must be at least 2");
      end
      if (DW <= VW) begin : g_bad_dw
         $error("ndiv_core: DW must exceed VW");
      end
   endgenerate

   logic          busy_q, done_q, dbz_q;
   ndiv_phase_e   phase_q;
   logic [CW-1:0] cnt_q;
   logic [SW-1:0] shamt_q;
   logic [VW-1:0] dvs_q, rem_q;
   logic [DW-1:0] dvd_q, quo_q;

   logic [VW-1:0] norm_dvs;
   logic [SW-1:0] norm_sh;
   logic [VW:0]   step_part;
   logic [VW-1:0] step_dsub, step_rem;
   logic          step_bit;
   logic          accept;

   ndiv_norm #(.VW(VW), .SW(SW)) u_norm (
      .dvs_in  (divisor),
      .dvs_norm(norm_dvs),
      .shamt   (norm_sh)
   );

   always_comb begin
      if (phase_q == PH_FIX) begin
         step_part = {1'b0, rem_q};
         step_dsub = dvs_q >> 1;
      end else begin
         step_part = {rem_q, dvd_q[DW-1]};
         step_dsub = dvs_q;
      end
   end

   ndiv_step #(.VW(VW)) u_step (
      .part   (step_part),
      .dsub   (step_dsub),
      .rem_out(step_rem),
      .qbit   (step_bit)
   );

   assign accept = start && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         dbz_q   <= 1'b0;
         phase_q <= PH_MAIN;
         cnt_q   <= '0;
         shamt_q <= '0;
         dvs_q   <= '0;
         rem_q   <= '0;
         dvd_q   <= '0;
         quo_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            if (divisor == '0) begin
               dbz_q  <= 1'b1;
               done_q <= 1'b1;
               quo_q  <= '1;
               rem_q  <= '0;
            end else begin
               dbz_q   <= 1'b0;
               busy_q  <= 1'b1;
               phase_q <= PH_MAIN;
               cnt_q   <= CW'(ITERS) + CW'(norm_sh);
               shamt_q <= norm_sh;
               dvs_q   <= norm_dvs;
               rem_q   <= VW'(dividend >> ITERS);
               dvd_q   <= dividend << (VW - 1);
               quo_q   <= '0;
            end
         end else if (busy_q) begin
            rem_q <= step_rem;
            quo_q <= {quo_q[DW-2:0], step_bit};
            cnt_q <= cnt_q - 1'b1;
            if (phase_q == PH_FIX) begin
               dvs_q <= dvs_q >> 1;
            end else begin
               dvd_q <= dvd_q << 1;
               if (cnt_q == CW'(shamt_q) + CW'(1)) phase_q <= PH_FIX;
            end
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy        = busy_q;
   assign done        = done_q;
   assign quotient    = quo_q;
   assign remainder   = rem_q;
   assign div_by_zero = dbz_q;
endmodule

// File: rtl/ndiv_chk.sv
module ndiv_chk #(
   parameter int DW = 16,
   parameter int VW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [DW-1:0] dividend,
   input logic [VW-1:0] divisor,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] quotient,
   input logic [VW-1:0] remainder,
   input logic          div_by_zero
);
   localparam int ITERS = DW - VW + 1;
   localparam int PW    = DW + VW;

   logic [DW-1:0] cap_a;
   logic [VW-1:0] cap_d;
   logic [7:0]    lat;
   logic [PW-1:0] rebuilt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a <= '0;
         cap_d <= '0;
         lat   <= '0;
      end else if (start && !busy) begin
         cap_a <= dividend;
         cap_d <= divisor;
         lat   <= 8'd1;
      end else if (busy) begin
         lat <= lat + 8'd1;
      end
   end

   assign rebuilt = PW'(quotient) * PW'(cap_d) + PW'(remainder);

   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_quot_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |-> (rebuilt == PW'(cap_a)));
   p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |-> (remainder < cap_d));
   p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |-> (cap_d == '0 && quotient == '1 && remainder == '0 && lat == 8'd1));
   p_latency_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |-> (lat >= 8'(ITERS + 1) && lat <= 8'(ITERS + VW)));
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind ndiv_core ndiv_chk #(.DW(DW), .VW(VW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .dividend   (dividend),
   .divisor    (divisor),
   .busy       (busy),
   .done       (done),
   .quotient   (quotient),
   .remainder  (remainder),
   .div_by_zero(div_by_zero)
);

// File: tb/ndiv_core_tb.sv
`timescale 1ns/1ps
module ndiv_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] dividend = '0;
   logic [3:0]  divisor = '0;
   logic        busy, done, div_by_zero;
   logic [15:0] quotient;
   logic [3:0]  remainder;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ndiv_core u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
      .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
      .remainder(remainder), .div_by_zero(div_by_zero)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lead_zeros(input int d);
      int s = 4;
      for (int i = 0; i < 4; i++) if (d[i]) s = 3 - i;
      return s;
   endfunction

   // Issue one operation and wait for done; n counts edges from acceptance (accepting edge = 1)
   task automatic run_op(input int a, input int d, output int n, output bit busy_ok);
      @(negedge clk);
      dividend = 16'(a);
      divisor  = 4'(d);
      start    = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      n       = 1;
      busy_ok = (d == 0) ? !busy : busy;
      while (!done && n < 40) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      if (busy) busy_ok = 1'b0;
   endtask

   task automatic check_op(input int a, input int d);
      int n;
      bit bok;
      run_op(a, d, n, bok);
      chk(n == 14 + lead_zeros(d), "R3 latency", n, 14 + lead_zeros(d));
      chk(quotient == 16'(a / d), "R4 quotient", quotient, a / d);
      chk(remainder == 4'(a % d), "R5 remainder", remainder, a % d);
      chk(bok, "R6 busy until done", int'(bok), 1);
      chk(!div_by_zero, "R10 flag clear", div_by_zero, 0);
   endtask

   task automatic t_reset;
      chk(!busy && !done && !div_by_zero, "R1 control outputs", {busy, done, div_by_zero}, 0);
      chk(quotient == 0 && remainder == 0, "R1 data outputs", quotient, 0);
   endtask

   task automatic t_accept;
      @(negedge clk);
      dividend = 16'd500;
      divisor  = 4'd9;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R2 busy after accept", busy, 1);
      while (!done) @(negedge clk);
      chk(quotient == 16'd55 && remainder == 4'd5, "R2 captured operands", quotient, 55);
   endtask

   task automatic t_shift_cases;
      check_op(1000, 10);
      check_op(12345, 7);
      check_op(100, 3);
      check_op(65535, 1);
      check_op(65535, 15);
      check_op(0, 5);
      check_op(9, 9);
      check_op(8, 2);
   endtask

   task automatic t_pulse;
      @(negedge clk);
      chk(!done, "R6 done one cycle", done, 0);
   endtask

   task automatic t_zero_div;
      int n;
      bit bok;
      run_op(1234, 0, n, bok);
      chk(n == 1, "R7 immediate done", n, 1);
      chk(bok, "R7 busy stays low", int'(bok), 1);
      chk(div_by_zero, "R7 flag", div_by_zero, 1);
      chk(quotient == 16'hFFFF && remainder == 0, "R7 saturated quotient", quotient, 65535);
      check_op(50, 3);
   endtask

   task automatic t_busy_start;
      int n;
      @(negedge clk);
      dividend = 16'd200;
      divisor  = 4'd6;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      repeat (4) begin @(negedge clk); n++; end
      dividend = 16'd999;
      divisor  = 4'd1;
      start    = 1'b1;
      @(negedge clk);
      n++;
      start = 1'b0;
      while (!done && n < 40) begin @(negedge clk); n++; end
      chk(n == 15, "R8 latency unchanged", n, 15);
      chk(quotient == 16'd33 && remainder == 4'd2, "R8 original operands", quotient, 33);
   endtask

   task automatic t_hold;
      logic [15:0] q0;
      logic [3:0]  r0;
      check_op(40000, 13);
      q0 = quotient;
      r0 = remainder;
      dividend = 16'd7;
      divisor  = 4'd0;
      repeat (6) @(negedge clk);
      chk(quotient == q0 && remainder == r0 && !div_by_zero, "R9 results held", quotient, q0);
   endtask

   task automatic t_sweep;
      for (int d = 1; d < 16; d++) begin
         int a;
         a = (d * 4099 + 7 * d + 3) & 16'hFFFF;
         check_op(a, d);
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_accept();
      t_shift_cases();
      t_pulse();
      t_zero_div();
      t_busy_start();
      t_hold();
      t_sweep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule